// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers interrupt requests from three kinds of source and hands one of them at a time to a processor core. The three kinds are one non-maskable input, a set of external request lines and a set of on-chip module request levels. Every maskable source has its own enable input. A single global mask input comes from the processor status word. While it is set, only the non-maskable source is let through. Requests that are blocked or that lose arbitration are kept, not discarded.

The block presents a request output and a 5-bit vector number. It holds that vector unchanged until the processor acknowledges it with a pulse that carries the same number. It also lets the vector go when the request it stands for stops being eligible. Edge-type sources keep a pending flag, and only an acknowledge with their vector clears it. Module sources are level inputs, and the module keeps its line high until it is serviced.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and no source is pending. Inputs held idle (`nmi_n` high, other requests low) raise no request.
- R2: A rising edge on `ext_req[i]` sets a pending flag for line i. The flag stays set until a cycle with `ack`=1 and `ack_vec` equal to that line's vector. An acknowledge carrying a different vector leaves both the flag and the presented vector unchanged.
- R3: A maskable source whose enable bit is 0 is never presented. An external line's pending flag is still kept while the line is disabled, and the request is presented once the enable becomes 1.
- R4: While `gmask`=1, only the non-maskable source can be presented. Maskable requests stay pending and are presented after `gmask` returns to 0.
- R5: A falling edge on `nmi_n` creates exactly one pending non-maskable event, whatever the value of `gmask`. Holding `nmi_n` low after that event is acknowledged raises no further request.
- R6: When several sources are eligible at once, the non-maskable source wins. It is followed by external lines in ascending index, then by module sources in ascending index.
- R7: The vector number is 3 for the non-maskable source, 4+i for external line i, and 12+j for module source j.
- R8: While `irq` is 1, `irq_vec` does not change, even if a higher-priority request arrives. In the cycle after a matching acknowledge, `irq` is 0, and arbitration then starts again.
- R9: A module request is presented while its level and its enable are both 1, and it is not latched. If the level falls while it is being presented, `irq` drops on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable request, active on the falling edge |
| ext_req | input | N_EXT | External request lines, active on the rising edge |
| ext_en | input | N_EXT | Per-line enables for the external sources |
| mod_req | input | N_MOD | Module request levels |
| mod_en | input | N_MOD | Per-source enables for the module sources |
| gmask | input | 1 | Global mask from the status word; 1 blocks maskable sources |
| ack | input | 1 | Acknowledge pulse from the processor |
| ack_vec | input | 5 | Vector number carried by the acknowledge |
| irq | output | 1 | Request to the processor |
| irq_vec | output | 5 | Vector number of the presented request |

## Verification
The hardest situation to reach is a true tie between an edge source and a level source. A module level becomes eligible one cycle before an external edge has been latched, so raising both together would let the module win by timing rather than by priority. The stimulus therefore raises each pair of sources while `gmask` is 1, lets the edges settle into their pending flags, and then clears the mask, so that every pair is really arbitrated in the same cycle. A sweep over all 256 enable combinations then serves every enabled source in priority order. It confirms that the disabled external flags survive, and finally drains them.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int VEC_W = 5;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int W       = 4,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    localparam logic [W-1:0] IDLE = FALLING ? {W{1'b1}} : {W{1'b0}};

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] edge_w;

    always_comb begin
        st_d      = st_q;
        edge_w    = FALLING ? (st_q.prev & ~sig) : (sig & ~st_q.prev);
        st_d.prev = sig;
        // a fresh edge wins over a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr) | edge_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= IDLE;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w != '0) |=> ((pend & $past(edge_w)) == $past(edge_w)));

    assert_pend_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 9,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     elig,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (elig[k]) begin
                any = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

    logic [N-1:0] below;
    always_comb begin
        below = (N'(1) << idx) - N'(1);
        if (any) begin
            assert_pick_valid_R6: assert (elig[idx])
                else $error("picked source not eligible");
            assert_pick_highest_R6: assert ((elig & below) == '0)
                else $error("higher priority source skipped");
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N_EXT   = 4,
    parameter int N_MOD   = 4,
    parameter int VEC_NMI = 3,
    parameter int VEC_EXT = 4,
    parameter int VEC_MOD = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nmi_n,
    input  logic [N_EXT-1:0]        ext_req,
    input  logic [N_EXT-1:0]        ext_en,
    input  logic [N_MOD-1:0]        mod_req,
    input  logic [N_MOD-1:0]        mod_en,
    input  logic                    gmask,
    input  logic                    ack,
    input  logic [irq_pkg::VEC_W-1:0] ack_vec,
    output logic                    irq,
    output logic [irq_pkg::VEC_W-1:0] irq_vec
);
    import irq_pkg::*;

    localparam int NSRC  = 1 + N_EXT + N_MOD;
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int NPAD  = 1 << IDX_W;
    localparam vec_t V_NMI = vec_t'(VEC_NMI);

    function automatic vec_t vec_of(input int unsigned k);
        if (k == 0)
            return V_NMI;
        else if (k <= N_EXT)
            return vec_t'(VEC_EXT + int'(k) - 1);
        else
            return vec_t'(VEC_MOD + int'(k) - 1 - N_EXT);
    endfunction

    typedef struct packed {
        logic             irq;
        logic [IDX_W-1:0] sel;
        vec_t             vec;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0]  ack_hit;
    logic             nmi_pend;
    logic [N_EXT-1:0] ext_pend;
    logic [NSRC-1:0]  elig;
    logic [NPAD-1:0]  elig_pad;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             ack_match;

    for (genvar k = 0; k < NSRC; k++) begin : g_hit
        assign ack_hit[k] = ack && (ack_vec == vec_of(k));
    end

    irq_edge_latch #(.W(1), .FALLING(1'b1)) i_nmi_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (nmi_n),
        .clr  (ack_hit[0]),
        .pend (nmi_pend)
    );

    irq_edge_latch #(.W(N_EXT), .FALLING(1'b0)) i_ext_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (ext_req),
        .clr  (ack_hit[N_EXT:1]),
        .pend (ext_pend)
    );

    assign elig[0] = nmi_pend;
    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        assign elig[1+i] = ext_pend[i] & ext_en[i] & ~gmask;
    end
    for (genvar j = 0; j < N_MOD; j++) begin : g_mod
        assign elig[1+N_EXT+j] = mod_req[j] & mod_en[j] & ~gmask;
    end
    assign elig_pad = NPAD'(elig);

    irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) i_pick (
        .elig(elig),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign ack_match = ack && (ack_vec == st_q.vec);

    always_comb begin
        st_d = st_q;
        if (st_q.irq) begin
            if (ack_match || !elig_pad[st_q.sel])
                st_d.irq = 1'b0;
        end else if (pick_any) begin
            st_d.irq = 1'b1;
            st_d.sel = pick_idx;
            st_d.vec = vec_of(int'(pick_idx));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.irq <= 1'b0;
            st_q.sel <= '0;
            st_q.vec <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign irq_vec = st_q.vec;

    assert_vec_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!irq || $stable(irq_vec)));

    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack && ack_vec == irq_vec) |=> !irq);

    assert_nmi_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !irq) |=> (irq && irq_vec == V_NMI));

    assert_mask_only_nmi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !irq) |=> (!irq || irq_vec == V_NMI));
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       nmi_n;
    logic [3:0] ext_req, ext_en, mod_req, mod_en;
    logic       gmask, ack;
    logic [4:0] ack_vec;
    logic       irq;
    logic [4:0] irq_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .ext_req(ext_req), .ext_en(ext_en),
        .mod_req(mod_req), .mod_en(mod_en), .gmask(gmask), .ack(ack), .ack_vec(ack_vec),
        .irq(irq), .irq_vec(irq_vec)
    );

    function automatic int ev(input int k);
        if (k == 0) return 3;
        if (k <= 4) return 4 + k - 1;
        return 12 + k - 5;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet(input string tag, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            chk(tag, int'(irq), 0);
        end
    endtask

    task automatic serve(input string tag, input int v);
        for (int w = 0; w < 10 && !irq; w++) @(negedge clk);
        chk({tag, " irq"}, int'(irq), 1);
        chk({tag, " vec"}, int'(irq_vec), v);
        ack     = 1'b1;
        ack_vec = 5'(v);
        if (v >= 12) mod_req[v-12] = 1'b0;
        @(negedge clk);
        ack = 1'b0;
        chk({tag, " R8 bubble"}, int'(irq), 0);
    endtask

    task automatic raise(input int k);
        if (k == 0) nmi_n = 1'b0;
        else if (k <= 4) ext_req[k-1] = 1'b1;
        else mod_req[k-5] = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; nmi_n = 1'b1; ext_req = '0; ext_en = '0; mod_req = '0;
        mod_en = '0; gmask = 1'b0; ack = 1'b0; ack_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset irq", int'(irq), 0);
        quiet("R1 idle", 3);

        // R5: NMI accepted under global mask, one event per edge
        gmask = 1'b1;
        nmi_n = 1'b0;
        serve("R5 nmi masked", 3);
        quiet("R5 held low", 5);
        nmi_n = 1'b1;

        // R4: masked external request held, then released
        ext_en = 4'hF;
        ext_req = 4'b0001; @(negedge clk); ext_req = '0;
        quiet("R4 masked", 5);
        gmask = 1'b0;
        serve("R4 released", 4);

        // R2: mismatched acknowledge leaves request in place
        ext_req = 4'b0010; @(negedge clk); ext_req = '0;
        for (int w = 0; w < 10 && !irq; w++) @(negedge clk);
        ack = 1'b1; ack_vec = 5'd6; @(negedge clk); ack = 1'b0;
        chk("R2 mismatch irq", int'(irq), 1);
        chk("R2 mismatch vec", int'(irq_vec), 5);
        serve("R2 match", 5);

        // R8: vector held when higher priority arrives
        ext_req = 4'b1000; @(negedge clk); ext_req = '0;
        for (int w = 0; w < 10 && !irq; w++) @(negedge clk);
        ext_req = 4'b0001; @(negedge clk); ext_req = '0;
        for (int c = 0; c < 3; c++) begin
            chk("R8 stable vec", int'(irq_vec), 7);
            @(negedge clk);
        end
        serve("R8 first", 7);
        serve("R8 second", 4);

        // R9: module level withdrawn
        mod_en = 4'hF;
        mod_req = 4'b0001;
        for (int w = 0; w < 10 && !irq; w++) @(negedge clk);
        chk("R9 mod vec", int'(irq_vec), 12);
        mod_req = '0;
        @(negedge clk);
        chk("R9 withdraw", int'(irq), 0);
        quiet("R9 quiet", 3);

        // R6/R7: every pair of sources arbitrated in the same cycle
        for (int a = 0; a < 9; a++) begin
            for (int b = a + 1; b < 9; b++) begin
                gmask = 1'b1;
                @(negedge clk);
                raise(a); raise(b);
                @(negedge clk);
                nmi_n = 1'b1; ext_req = '0;
                repeat (3) @(negedge clk);
                gmask = 1'b0;
                serve("R6 pair high", ev(a));
                serve("R7 pair low", ev(b));
            end
        end

        // R3: sweep of all enable combinations
        for (int m = 0; m < 256; m++) begin
            gmask = 1'b1;
            ext_en = m[3:0]; mod_en = m[7:4];
            @(negedge clk);
            ext_req = 4'hF; mod_req = 4'hF;
            @(negedge clk);
            ext_req = '0;
            repeat (2) @(negedge clk);
            gmask = 1'b0;
            for (int i = 0; i < 4; i++) if (m[i]) serve("R3 ext", 4 + i);
            for (int j = 0; j < 4; j++) if (m[4+j]) serve("R9 mod", 12 + j);
            quiet("R3 disabled", 3);
            mod_req = '0;
            ext_en = 4'hF;
            for (int i = 0; i < 4; i++) if (!m[i]) serve("R3 retained", 4 + i);
            quiet("R3 drained", 2);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule